// File: doc/BRIEF.md
# Link Event Statistics Counter Bank

This block keeps running totals of two kinds of link event. The first is each time the link enable control goes from low to high. The second is each rising edge on any of eight raw interrupt sources. The interrupt edges are taken before any masking, so software can see how often every source fired, whether or not it was allowed to interrupt. Each total is a 16-bit counter that saturates at its maximum value rather than wrapping.

Software reads the counters through a small word-addressed register port. The link enable total has a word of its own. The interrupt totals are packed two to a 32-bit word. A control word at the bottom of the window clears every counter when bit 0 is written as 1.

The register port is plain control and has no back-pressure. A read strobe is always accepted. The requested word appears on the read data one clock later, together with a one-cycle valid pulse. The read data holds its value between reads. A write strobe takes effect at the same clock edge that samples it.

Top module: `link_event_stats`

## Requirements
- R1: After reset every counter is 0, `reg_rvalid` is low and `reg_rdata` is 0. Reading any counter word before the first event returns 0.
- R2: A low-to-high transition of `link_en` adds one to the link enable counter. The counter is read at word address 0x0B1 in bits [15:0], with bits [31:16] reading 0. The previous-level register resets to 0, so a level that is already high in the first cycle after reset also counts once.
- R3: A low-to-high transition of `irq_raw[i]` adds one to counter i. There is no mask input: every edge counts. Word address 0x0B4+k holds counter 2k in bits [15:0] and counter 2k+1 in bits [31:16], for k = 0 to 3.
- R4: A source or enable level that is held high counts once. It counts again only after it has gone low and then risen again.
- R5: Each counter stops at 0xFFFF. Further events leave it at 0xFFFF.
- R6: A write to word address 0x0B0 with bit 0 set clears every counter at that clock edge. A write to 0x0B0 with bit 0 clear, or a write to any other address, changes no counter.
- R7: When a clear and an event fall in the same cycle, the affected counter ends at 0.
- R8: A read of 0x0B0 returns 0, because the clear bit is write-only and self-clearing. A read of any address outside 0x0B0, 0x0B1 and 0x0B4 to 0x0B7 also returns 0.
- R9: `reg_rvalid` is high in exactly the cycle after a cycle with `reg_rd` high. `reg_rdata` then shows the word as it stood before the clock edge that sampled the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_en | input | 1 | Link enable level |
| irq_raw | input | 8 | Raw interrupt source levels, before masking |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Word address shared by reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` and held between reads |
| reg_rvalid | output | 1 | One-cycle pulse marking new read data |

## Verification
Sparse random interrupt patterns with frequently toggling enable levels test the rise detection. A pattern where a level stays high distinguishes edge counting from level counting. Directed pulses on a single source show whether each counter lands in the correct half of the correct packed word. Random clears mixed with events check that a clear wins over an event in the same cycle, and writes of 0 or to other addresses confirm that those writes are ignored. A long train of edges on one source pushes its counter past 0xFFFF, which tells saturation apart from wrapping. Reads of the control word and of unmapped addresses must return 0.

// File: rtl/link_stats_pkg.sv
package link_stats_pkg;
  localparam int unsigned LS_ADDR_W = 12;
  localparam int unsigned LS_DATA_W = 32;
  localparam int unsigned LS_CNT_W  = 16;
  localparam int unsigned LS_N_IRQ  = 8;
  localparam logic [LS_ADDR_W-1:0] LS_CTRL_ADDR = 12'h0B0;
  localparam logic [LS_ADDR_W-1:0] LS_LINK_ADDR = 12'h0B1;
  localparam logic [LS_ADDR_W-1:0] LS_IRQ_BASE  = 12'h0B4;
endpackage

// File: rtl/lstat_rise_det.sv
module lstat_rise_det #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/lstat_sat_cnt.sv
module lstat_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr)                  cnt_q <= '0;
    else if (inc && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/lstat_rd_port.sv
module lstat_rd_port #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_IRQ  = 8,
  parameter logic [ADDR_W-1:0] LINK_ADDR = '0,
  parameter logic [ADDR_W-1:0] IRQ_BASE  = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [CNT_W-1:0]       link_cnt,
  input  logic [N_IRQ*CNT_W-1:0] irq_cnt,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rvalid
);
  localparam int unsigned N_WORDS = N_IRQ / 2;

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    word = '0;
    if (addr == LINK_ADDR) word[CNT_W-1:0] = link_cnt;
    for (int k = 0; k < N_WORDS; k++) begin
      if (addr == IRQ_BASE + ADDR_W'(k)) begin
        word[0 +: CNT_W]     = irq_cnt[(2*k)*CNT_W +: CNT_W];
        word[CNT_W +: CNT_W] = irq_cnt[(2*k+1)*CNT_W +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= word;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/link_event_stats.sv
module link_event_stats
  import link_stats_pkg::*;
#(
  parameter int unsigned ADDR_W = LS_ADDR_W,
  parameter int unsigned DATA_W = LS_DATA_W,
  parameter int unsigned CNT_W  = LS_CNT_W,
  parameter int unsigned N_IRQ  = LS_N_IRQ,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = LS_CTRL_ADDR,
  parameter logic [ADDR_W-1:0] LINK_ADDR = LS_LINK_ADDR,
  parameter logic [ADDR_W-1:0] IRQ_BASE  = LS_IRQ_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic [N_IRQ-1:0]  irq_raw,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid
);
  localparam int unsigned N_EV = N_IRQ + 1;

  logic                   clr_all;
  logic [N_EV-1:0]        ev_level;
  logic [N_EV-1:0]        ev_rise;
  logic [CNT_W-1:0]       link_cnt;
  logic [N_IRQ*CNT_W-1:0] irq_cnt;
  logic                   unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:1];

  always_comb begin
    clr_all = reg_wr && (reg_addr == CTRL_ADDR) && reg_wdata[0];
  end

  assign ev_level = {irq_raw, link_en};

  lstat_rise_det #(.W(N_EV)) edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .level (ev_level),
    .rise  (ev_rise)
  );

  lstat_sat_cnt #(.W(CNT_W)) link_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ev_rise[0]),
    .clr   (clr_all),
    .count (link_cnt)
  );

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    lstat_sat_cnt #(.W(CNT_W)) irq_cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev_rise[i+1]),
      .clr   (clr_all),
      .count (irq_cnt[i*CNT_W +: CNT_W])
    );
  end

  lstat_rd_port #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .N_IRQ     (N_IRQ),
    .LINK_ADDR (LINK_ADDR),
    .IRQ_BASE  (IRQ_BASE)
  ) rd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .link_cnt (link_cnt),
    .irq_cnt  (irq_cnt),
    .rdata    (reg_rdata),
    .rvalid   (reg_rvalid)
  );
endmodule

// File: rtl/link_event_stats_chk.sv
module link_event_stats_chk
  import link_stats_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [LS_ADDR_W-1:0] reg_addr,
  input logic                 wr_bit0,
  input logic                 reg_rd,
  input logic [LS_DATA_W-1:0] reg_rdata,
  input logic                 reg_rvalid
);
  logic is_cnt_word;
  logic is_clear;

  assign is_cnt_word = (reg_addr == LS_LINK_ADDR) ||
                       (reg_addr >= LS_IRQ_BASE &&
                        reg_addr <  LS_IRQ_BASE + 12'(LS_N_IRQ / 2));
  assign is_clear    = reg_wr && (reg_addr == LS_CTRL_ADDR) && wr_bit0;

  // R9
  rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  // R9
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !is_cnt_word) |=> (reg_rdata == '0));

  // R2
  link_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == LS_LINK_ADDR) |=> (reg_rdata[31:16] == 16'h0));

  // R6
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_clear ##1 (reg_rd && is_cnt_word) |=> (reg_rdata == '0));
endmodule

bind link_event_stats link_event_stats_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .wr_bit0    (reg_wdata[0]),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid)
);

// File: tb/link_event_stats_tb_top.sv
`timescale 1ns/1ps
module link_event_stats_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_en = 1'b0;
  logic [7:0]  irq_raw = '0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int unsigned m_link;
  int unsigned m_irq [8];
  logic        m_prev_link;
  logic [7:0]  m_prev_irq;

  always #2 clk = ~clk;

  link_event_stats dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_en    (link_en),
    .irq_raw    (irq_raw),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
  );

  function automatic logic [31:0] exp_word(input logic [11:0] a);
    case (a)
      12'h0B1: return {16'h0, m_link[15:0]};
      12'h0B4: return {m_irq[1][15:0], m_irq[0][15:0]};
      12'h0B5: return {m_irq[3][15:0], m_irq[2][15:0]};
      12'h0B6: return {m_irq[5][15:0], m_irq[4][15:0]};
      12'h0B7: return {m_irq[7][15:0], m_irq[6][15:0]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(input logic [11:0] a);
    if (a == 12'h0B1) return "R2";
    if (a >= 12'h0B4 && a <= 12'h0B7) return "R3";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step(input logic le, input logic [7:0] irq, input logic wr,
                      input logic [11:0] a, input logic [31:0] wd, input logic rd,
                      input string req);
    logic [31:0] expv;
    logic        clr;
    @(negedge clk);
    link_en = le; irq_raw = irq; reg_wr = wr; reg_addr = a; reg_wdata = wd; reg_rd = rd;
    expv = exp_word(a);
    @(posedge clk);
    clr = wr && (a == 12'h0B0) && wd[0];
    if (clr) m_link = 0;
    else if (le && !m_prev_link && m_link < 32'hFFFF) m_link++;
    m_prev_link = le;
    for (int i = 0; i < 8; i++) begin
      if (clr) m_irq[i] = 0;
      else if (irq[i] && !m_prev_irq[i] && m_irq[i] < 32'hFFFF) m_irq[i]++;
    end
    m_prev_irq = irq;
    #1;
    if (rd) begin
      check({req, " rvalid"}, {31'h0, reg_rvalid}, 32'h1);
      check(req, reg_rdata, expv);
    end else if (reg_rvalid !== 1'b0) begin
      check("R9 rvalid idle", {31'h0, reg_rvalid}, 32'h0);
    end
  endtask

  task automatic rd_word(input logic [11:0] a, input string req);
    step(link_en, irq_raw, 1'b0, a, 32'h0, 1'b1, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17_0C3D));
    m_link = 0; m_prev_link = 0; m_prev_irq = '0;
    for (int i = 0; i < 8; i++) m_irq[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state at the ports
    check("R1 rvalid", {31'h0, reg_rvalid}, 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    rd_word(12'h0B1, "R1");
    for (int k = 0; k < 4; k++) rd_word(12'h0B4 + 12'(k), "R1");

    // R2 link enable edges
    for (int n = 0; n < 3; n++) begin
      step(1'b1, '0, 1'b0, 12'h0, 32'h0, 1'b0, "R2");
      step(1'b0, '0, 1'b0, 12'h0, 32'h0, 1'b0, "R2");
    end
    rd_word(12'h0B1, "R2");

    // R3 packing: pulse each source a distinct number of times
    for (int s = 0; s < 8; s++)
      for (int n = 0; n <= s; n++) begin
        step(1'b0, 8'(1 << s), 1'b0, 12'h0, 32'h0, 1'b0, "R3");
        step(1'b0, 8'h00, 1'b0, 12'h0, 32'h0, 1'b0, "R3");
      end
    for (int k = 0; k < 4; k++) rd_word(12'h0B4 + 12'(k), "R3");

    // R4 held high counts once
    for (int n = 0; n < 10; n++) step(1'b1, 8'h08, 1'b0, 12'h0, 32'h0, 1'b0, "R4");
    rd_word(12'h0B5, "R4");
    rd_word(12'h0B1, "R4");

    // R6 ignored writes
    step(1'b0, 8'h00, 1'b1, 12'h0B0, 32'hFFFF_FFFE, 1'b0, "R6");
    step(1'b0, 8'h00, 1'b1, 12'h0B1, 32'h1, 1'b0, "R6");
    step(1'b0, 8'h00, 1'b1, 12'h0B4, 32'h1, 1'b0, "R6");
    rd_word(12'h0B1, "R6");
    rd_word(12'h0B4, "R6");
    // R6 real clear
    step(1'b0, 8'h00, 1'b1, 12'h0B0, 32'h1, 1'b0, "R6");
    for (int k = 0; k < 4; k++) rd_word(12'h0B4 + 12'(k), "R6");
    rd_word(12'h0B1, "R6");

    // R7 clear with simultaneous edges
    step(1'b0, 8'h00, 1'b0, 12'h0, 32'h0, 1'b0, "R7");
    step(1'b1, 8'hFF, 1'b1, 12'h0B0, 32'h1, 1'b0, "R7");
    rd_word(12'h0B1, "R7");
    rd_word(12'h0B7, "R7");

    // R8 control and unmapped reads
    rd_word(12'h0B0, "R8");
    rd_word(12'h0B2, "R8");
    rd_word(12'h0B3, "R8");
    rd_word(12'h0B8, "R8");
    rd_word(12'h000, "R8");

    // Random mix (R2 R3 R6 R7 R8 R9)
    for (int c = 0; c < 4000; c++) begin
      logic        le;
      logic [7:0]  irq;
      logic        wr;
      logic        rd;
      logic [11:0] a;
      int unsigned pick;
      le  = (($urandom % 4) == 0) ? ~link_en : link_en;
      irq = 8'($urandom & $urandom & $urandom);
      wr  = (($urandom % 60) == 0);
      rd  = (($urandom % 2) == 0);
      pick = $urandom % 10;
      case (pick)
        0: a = 12'h0B0;
        1: a = 12'h0B1;
        2: a = 12'h0B2;
        3: a = 12'h0B8;
        4: a = 12'h000;
        default: a = 12'h0B4 + 12'(pick - 5);
      endcase
      if (wr) a = 12'h0B0;
      step(le, irq, wr, a, $urandom, rd, tag_for(a));
    end

    // R5 saturation on source 5
    step(1'b0, 8'h00, 1'b1, 12'h0B0, 32'h1, 1'b0, "R5");
    for (int n = 0; n < 65540; n++) begin
      step(1'b0, 8'h20, 1'b0, 12'h0, 32'h0, 1'b0, "R5");
      step(1'b0, 8'h00, 1'b0, 12'h0, 32'h0, 1'b0, "R5");
    end
    rd_word(12'h0B6, "R5");
    check("R5 saturated field", {16'h0, reg_rdata[31:16]}, 32'h0000_FFFF);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule